// File: doc/BRIEF.md
# Fractional-rate time-of-day clock with pulse-per-second output

This block keeps a free-running time of day as three 32-bit words: whole seconds, nanoseconds inside the second, and a residue that counts fractions of a nanosecond in steps of 2^-32 ns. On every clock cycle it adds a fixed nominal period of 12.5 ns to the time. It also adds a signed fine-trim value, so the net step always lies between 12 and 13 ns. The residue collects the fractional part of each step and carries into the nanosecond word. A trim of a few 2^-32 ns units therefore shifts the rate with no loss over time. The clock rate does not depend on anything outside the block.

Control logic writes the trim word. It can load an absolute time, apply a signed nanosecond step to the running time, and request a snapshot of all three words that are captured in one cycle. The nanosecond word rolls into the seconds word at one billion. A step may borrow from the seconds word or carry into it.

A pulse-per-second generator arms itself on the next whole second when it is enabled. At each target second it raises its output for a programmable number of nanoseconds, then moves the target forward by exactly one second.

Top module: `tod_clock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the seconds, nanoseconds, residue and trim are all zero, `pps_out` is low and `snap_valid` is low.
- R2: In a cycle with no load and no step, the time grows by 12.5 ns plus the trim, both taken in units of 2^-32 ns. The trim is read as bit 31 = sign (1 means subtract) and bits 30:0 = magnitude. The residue carries into nanoseconds, so the nanosecond word always grows by 12 or 13.
- R3: A trim write takes effect on the increment of the cycle after the write cycle. It does not affect the increment of the write cycle itself.
- R4: The nanosecond word never reaches 1,000,000,000. Passing that value subtracts one billion and adds one second. The seconds word wraps from 0xFFFFFFFF to 0.
- R5: A load sets seconds and nanoseconds to the given values and the residue to zero, all visible in the next cycle. When a load and a step arrive in the same cycle, the load wins.
- R6: A step adds a signed two's-complement nanosecond offset (magnitude below one billion) on top of that cycle's normal increment. A result that is negative or at least one billion borrows from the seconds word or carries into it. Stepping below second 0 wraps to 0xFFFFFFFF.
- R7: A snapshot request captures the seconds, nanoseconds and residue present in the request cycle. They appear on the snapshot outputs in the next cycle, and `snap_valid` is high for exactly that one cycle.
- R8: Raising `pps_en` while the generator is idle sets the target to the next whole second, which is the current second + 1 at 0 ns. While `pps_en` is low the output drops and the target is disarmed from the next cycle on.
- R9: The pulse output rises in the cycle after the sampled time first reaches the target. The target then moves forward by exactly one second. The output falls in the cycle after the time reaches the matched second plus `pps_width_ns` (1 to 999,999,999) nanoseconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trim_we | input | 1 | Write strobe for the trim word |
| trim_wdata | input | 32 | Signed-magnitude trim, 2^-32 ns units |
| load_en | input | 1 | Load an absolute time |
| load_sec | input | 32 | Seconds value to load |
| load_ns | input | 32 | Nanoseconds value to load (below one billion) |
| step_en | input | 1 | Apply a nanosecond step |
| step_ns | input | 32 | Signed step in nanoseconds |
| snap_req | input | 1 | Snapshot request |
| snap_valid | output | 1 | Snapshot words are valid this cycle |
| snap_sec | output | 32 | Captured seconds |
| snap_ns | output | 32 | Captured nanoseconds |
| snap_frac | output | 32 | Captured residue |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |
| pps_en | input | 1 | Enable for the pulse-per-second generator |
| pps_width_ns | input | 32 | Pulse width in nanoseconds |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
Two functions can land in the same cycle: a step and the normal increment's rollover into the next second. The bench provokes this by loading a time a few nanoseconds below a whole second and stepping at once, both forward and backward. The bench judges the outcome against a reference model that keeps time as a single signed count of nanoseconds, so the carry and borrow fall out of plain division. Loads that coincide with a step, and a pulse target that is reached right after a load, are compared against the same model on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;

   // Nanoseconds in one second: the rollover point of the nanosecond word
   localparam int unsigned TOD_NS_PER_SEC = 1_000_000_000;

   // Pulse generator states
   typedef enum logic [1:0] {
      PPS_IDLE  = 2'd0,
      PPS_ARMED = 2'd1,
      PPS_HIGH  = 2'd2
   } pps_state_e;

endpackage

// File: rtl/tod_rate.sv
// Holds the trim word and forms the per-cycle increment (nominal +/- trim),
// split into a whole-nanosecond part and a 2^-FRAC_W ns fraction.
module tod_rate #(
   parameter int FRAC_W   = 32,
   parameter int INC_NS_W = 4,
   parameter int BASE_NS  = 12,
   parameter logic [FRAC_W-1:0] BASE_FRAC = {1'b1, {(FRAC_W-1){1'b0}}}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trim_we,
   input  logic [FRAC_W-1:0]   trim_wdata,
   output logic [INC_NS_W-1:0] inc_ns,
   output logic [FRAC_W-1:0]   inc_frac
);
   localparam int TOT_W = INC_NS_W + FRAC_W;
   localparam logic [TOT_W-1:0] BASE_TOT = {INC_NS_W'(BASE_NS), BASE_FRAC};

   logic [FRAC_W-1:0] trim_q;
   logic [TOT_W-1:0]  trim_mag;
   logic [TOT_W-1:0]  inc_tot;

   generate
      if (BASE_NS + 1 >= (1 << INC_NS_W)) begin : g_bad_inc_w
         $error("tod_rate: INC_NS_W too narrow for BASE_NS");
      end
      if (FRAC_W < 8) begin : g_bad_frac_w
         $error("tod_rate: FRAC_W must be at least 8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
      end else if (trim_we) begin
         trim_q <= trim_wdata;
      end
   end

   always_comb begin
      trim_mag = {{(INC_NS_W + 1){1'b0}}, trim_q[FRAC_W-2:0]};
      if (trim_q[FRAC_W-1]) begin
         inc_tot = BASE_TOT - trim_mag;
      end else begin
         inc_tot = BASE_TOT + trim_mag;
      end
   end

   assign inc_ns   = inc_tot[TOT_W-1:FRAC_W];
   assign inc_frac = inc_tot[FRAC_W-1:0];

   // R3
   trim_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trim_we |=> $stable(inc_tot))
      else $error("trim_latency_chk");

endmodule

// File: rtl/tod_counter.sv
// Seconds / nanoseconds / residue state with load, signed step and rollover.
module tod_counter #(
   parameter int          SEC_W    = 32,
   parameter int          NS_W     = 32,
   parameter int          FRAC_W   = 32,
   parameter int          INC_NS_W = 4,
   parameter int unsigned NS_ROLL  = tod_pkg::TOD_NS_PER_SEC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [INC_NS_W-1:0] inc_ns,
   input  logic [FRAC_W-1:0]   inc_frac,
   input  logic                load_en,
   input  logic [SEC_W-1:0]    load_sec,
   input  logic [NS_W-1:0]     load_ns,
   input  logic                step_en,
   input  logic [NS_W-1:0]     step_ns,
   output logic [SEC_W-1:0]    sec_q,
   output logic [NS_W-1:0]     ns_q,
   output logic [FRAC_W-1:0]   frac_q
);
   // two guard bits: one for the sum overflow, one for the sign
   localparam int NSX = NS_W + 2;
   localparam logic [NSX-1:0] ROLL_X = NSX'(NS_ROLL);

   logic [FRAC_W:0]   frac_sum;
   logic [NSX-1:0]    step_x;
   logic [NSX-1:0]    ns_sum;
   logic              roll_up;
   logic              roll_dn;
   logic [NSX-1:0]    ns_fix;
   logic [SEC_W-1:0]  sec_nxt;
   logic [NS_W-1:0]   ns_nxt;
   logic [FRAC_W-1:0] frac_nxt;

   generate
      if (longint'(NS_ROLL) >= (longint'(1) << (NS_W - 1))) begin : g_bad_ns_w
         $error("tod_counter: NS_W too narrow for a signed step of one second");
      end
      if (SEC_W < 2) begin : g_bad_sec_w
         $error("tod_counter: SEC_W must be at least 2");
      end
   endgenerate

   always_comb begin
      frac_sum = {1'b0, frac_q} + {1'b0, inc_frac};
      step_x   = step_en ? {{2{step_ns[NS_W-1]}}, step_ns} : '0;
      ns_sum   = {2'b00, ns_q} + NSX'(inc_ns) + NSX'(frac_sum[FRAC_W]) + step_x;
      roll_dn  = ns_sum[NSX-1];
      roll_up  = !ns_sum[NSX-1] && (ns_sum >= ROLL_X);
      if (roll_up) begin
         ns_fix  = ns_sum - ROLL_X;
         sec_nxt = sec_q + SEC_W'(1);
      end else if (roll_dn) begin
         ns_fix  = ns_sum + ROLL_X;
         sec_nxt = sec_q - SEC_W'(1);
      end else begin
         ns_fix  = ns_sum;
         sec_nxt = sec_q;
      end
      ns_nxt   = ns_fix[NS_W-1:0];
      frac_nxt = frac_sum[FRAC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         ns_q   <= '0;
         frac_q <= '0;
      end else if (load_en) begin
         sec_q  <= load_sec;
         ns_q   <= load_ns;
         frac_q <= '0;
      end else begin
         sec_q  <= sec_nxt;
         ns_q   <= ns_nxt;
         frac_q <= frac_nxt;
      end
   end

   // R4
   ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ns_q < NS_W'(NS_ROLL))
      else $error("ns_range_chk");

   // R2
   ns_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !step_en) |=>
         ((longint'(ns_q) - longint'($past(ns_q))
           + ((ns_q < $past(ns_q)) ? longint'(NS_ROLL) : 64'sd0)) >= longint'($past(inc_ns)))
      && ((longint'(ns_q) - longint'($past(ns_q))
           + ((ns_q < $past(ns_q)) ? longint'(NS_ROLL) : 64'sd0)) <= longint'($past(inc_ns)) + 1))
      else $error("ns_advance_chk");

   // R4
   sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !step_en) |=>
         ((sec_q == $past(sec_q) + SEC_W'(1)) == (ns_q < $past(ns_q))))
      else $error("sec_carry_chk");

   // R5
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (sec_q == $past(load_sec)) && (ns_q == $past(load_ns)) && (frac_q == '0))
      else $error("load_take_chk");

endmodule

// File: rtl/tod_pps.sv
// Target-time comparator driving a pulse at every whole second.
module tod_pps #(
   parameter int SEC_W = 32,
   parameter int NS_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pps_en,
   input  logic [NS_W-1:0]  width_ns,
   input  logic [SEC_W-1:0] sec_q,
   input  logic [NS_W-1:0]  ns_q,
   output logic             pps_o
);
   import tod_pkg::*;

   pps_state_e       state_q;
   logic [SEC_W-1:0] tgt_sec_q;
   logic [SEC_W-1:0] end_sec_q;
   logic [NS_W-1:0]  end_ns_q;
   logic             at_target;
   logic             past_end;

   assign at_target = {sec_q, ns_q} >= {tgt_sec_q, {NS_W{1'b0}}};
   assign past_end  = {sec_q, ns_q} >= {end_sec_q, end_ns_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PPS_IDLE;
         tgt_sec_q <= '0;
         end_sec_q <= '0;
         end_ns_q  <= '0;
      end else if (!pps_en) begin
         state_q <= PPS_IDLE;
      end else if (state_q == PPS_IDLE) begin
         tgt_sec_q <= sec_q + SEC_W'(1);
         state_q   <= PPS_ARMED;
      end else if (at_target) begin
         state_q   <= PPS_HIGH;
         end_sec_q <= tgt_sec_q;
         end_ns_q  <= width_ns;
         tgt_sec_q <= tgt_sec_q + SEC_W'(1);
      end else if ((state_q == PPS_HIGH) && past_end) begin
         state_q <= PPS_ARMED;
      end
   end

   assign pps_o = (state_q == PPS_HIGH);

   // R8
   pps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pps_en |=> !pps_o)
      else $error("pps_off_chk");

   // R8
   pps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pps_en && (state_q == PPS_IDLE)) |=> (tgt_sec_q == $past(sec_q) + SEC_W'(1)))
      else $error("pps_arm_chk");

   // R9
   pps_target_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pps_en && (state_q != PPS_IDLE) && at_target) |=>
         (tgt_sec_q == $past(tgt_sec_q) + SEC_W'(1)) && pps_o)
      else $error("pps_target_step_chk");

endmodule

// File: rtl/tod_clock.sv
// Top: rate generator, time counter, snapshot capture and optional pulse output.
module tod_clock #(
   parameter int          SEC_W     = 32,
   parameter int          NS_W      = 32,
   parameter int          FRAC_W    = 32,
   parameter int          BASE_NS   = 12,
   parameter logic [FRAC_W-1:0] BASE_FRAC = {1'b1, {(FRAC_W-1){1'b0}}},
   parameter int unsigned NS_ROLL   = tod_pkg::TOD_NS_PER_SEC,
   parameter bit          HAS_PPS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trim_we,
   input  logic [FRAC_W-1:0] trim_wdata,
   input  logic              load_en,
   input  logic [SEC_W-1:0]  load_sec,
   input  logic [NS_W-1:0]   load_ns,
   input  logic              step_en,
   input  logic [NS_W-1:0]   step_ns,
   input  logic              snap_req,
   output logic              snap_valid,
   output logic [SEC_W-1:0]  snap_sec,
   output logic [NS_W-1:0]   snap_ns,
   output logic [FRAC_W-1:0] snap_frac,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns,
   input  logic              pps_en,
   input  logic [NS_W-1:0]   pps_width_ns,
   output logic              pps_out
);
   localparam int INC_NS_W = $clog2(BASE_NS + 2);

   logic [INC_NS_W-1:0] inc_ns;
   logic [FRAC_W-1:0]   inc_frac;
   logic [SEC_W-1:0]    sec_q;
   logic [NS_W-1:0]     ns_q;
   logic [FRAC_W-1:0]   frac_q;

   generate
      if (BASE_NS < 1) begin : g_bad_base
         $error("tod_clock: BASE_NS must be positive");
      end
   endgenerate

   tod_rate #(
      .FRAC_W   (FRAC_W),
      .INC_NS_W (INC_NS_W),
      .BASE_NS  (BASE_NS),
      .BASE_FRAC(BASE_FRAC)
   ) i_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .trim_we   (trim_we),
      .trim_wdata(trim_wdata),
      .inc_ns    (inc_ns),
      .inc_frac  (inc_frac)
   );

   tod_counter #(
      .SEC_W   (SEC_W),
      .NS_W    (NS_W),
      .FRAC_W  (FRAC_W),
      .INC_NS_W(INC_NS_W),
      .NS_ROLL (NS_ROLL)
   ) i_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_ns  (inc_ns),
      .inc_frac(inc_frac),
      .load_en (load_en),
      .load_sec(load_sec),
      .load_ns (load_ns),
      .step_en (step_en),
      .step_ns (step_ns),
      .sec_q   (sec_q),
      .ns_q    (ns_q),
      .frac_q  (frac_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_sec   <= '0;
         snap_ns    <= '0;
         snap_frac  <= '0;
      end else begin
         snap_valid <= snap_req;
         if (snap_req) begin
            snap_sec  <= sec_q;
            snap_ns   <= ns_q;
            snap_frac <= frac_q;
         end
      end
   end

   assign tod_sec = sec_q;
   assign tod_ns  = ns_q;

   generate
      if (HAS_PPS) begin : g_pps
         tod_pps #(
            .SEC_W(SEC_W),
            .NS_W (NS_W)
         ) i_pps (
            .clk     (clk),
            .rst_n   (rst_n),
            .pps_en  (pps_en),
            .width_ns(pps_width_ns),
            .sec_q   (sec_q),
            .ns_q    (ns_q),
            .pps_o   (pps_out)
         );
      end else begin : g_no_pps
         assign pps_out = 1'b0;
      end
   endgenerate

   // R7
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> snap_valid && (snap_sec == $past(tod_sec)) && (snap_ns == $past(tod_ns)))
      else $error("snap_capture_chk");

   // R7
   snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> !snap_valid)
      else $error("snap_single_chk");

endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;
   localparam longint ROLL  = 64'sd1000000000;
   localparam longint M32   = 64'sd4294967296;
   localparam longint MODT  = M32 * ROLL;
   localparam longint NOM   = 64'sd53687091200; // 12.5 ns in 2^-32 ns units

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trim_we = 1'b0;
   logic [31:0] trim_wdata = '0;
   logic        load_en = 1'b0;
   logic [31:0] load_sec = '0;
   logic [31:0] load_ns = '0;
   logic        step_en = 1'b0;
   logic [31:0] step_ns = '0;
   logic        snap_req = 1'b0;
   logic        snap_valid;
   logic [31:0] snap_sec, snap_ns, snap_frac;
   logic [31:0] tod_sec, tod_ns;
   logic        pps_en = 1'b0;
   logic [31:0] pps_width_ns = 32'd200;
   logic        pps_out;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #4 clk = ~clk;

   tod_clock i_tod_clock (
      .clk(clk), .rst_n(rst_n),
      .trim_we(trim_we), .trim_wdata(trim_wdata),
      .load_en(load_en), .load_sec(load_sec), .load_ns(load_ns),
      .step_en(step_en), .step_ns(step_ns),
      .snap_req(snap_req), .snap_valid(snap_valid),
      .snap_sec(snap_sec), .snap_ns(snap_ns), .snap_frac(snap_frac),
      .tod_sec(tod_sec), .tod_ns(tod_ns),
      .pps_en(pps_en), .pps_width_ns(pps_width_ns), .pps_out(pps_out)
   );

   // reference model: time kept as one signed nanosecond count
   longint m_sec, m_ns, m_frac, m_trim;
   longint e_ssec, e_sns, e_sfrac;
   bit     e_sv;
   int     m_st;
   longint m_tsec, m_esec, m_ens;

   always @(posedge clk or negedge rst_n) begin : model
      longint inc, fsum, tot, o_sec, o_ns;
      if (!rst_n) begin
         m_sec = 0; m_ns = 0; m_frac = 0; m_trim = 0;
         e_sv = 1'b0; e_ssec = 0; e_sns = 0; e_sfrac = 0;
         m_st = 0; m_tsec = 0; m_esec = 0; m_ens = 0;
      end else begin
         o_sec = m_sec;
         o_ns  = m_ns;
         inc = m_trim[31] ? NOM - (m_trim & 64'h7FFFFFFF) : NOM + (m_trim & 64'h7FFFFFFF);
         e_sv = snap_req;
         if (snap_req) begin
            e_ssec = m_sec; e_sns = m_ns; e_sfrac = m_frac;
         end
         if (m_st == 0) begin
            if (pps_en) begin
               m_tsec = (o_sec + 1) % M32;
               m_st = 1;
            end
         end else if (!pps_en) begin
            m_st = 0;
         end else if (o_sec * ROLL + o_ns >= m_tsec * ROLL) begin
            m_st = 2;
            m_esec = m_tsec;
            m_ens = longint'(pps_width_ns);
            m_tsec = (m_tsec + 1) % M32;
         end else if (m_st == 2 && (o_sec * ROLL + o_ns >= m_esec * ROLL + m_ens)) begin
            m_st = 1;
         end
         if (load_en) begin
            m_sec = longint'(load_sec); m_ns = longint'(load_ns); m_frac = 0;
         end else begin
            fsum = m_frac + inc;
            m_frac = fsum % M32;
            tot = m_sec * ROLL + m_ns + (fsum / M32)
                  + (step_en ? longint'($signed(step_ns)) : 64'sd0);
            tot = tot % MODT;
            if (tot < 0) tot = tot + MODT;
            m_sec = tot / ROLL;
            m_ns  = tot % ROLL;
         end
         if (trim_we) m_trim = longint'(trim_wdata);
      end
   end

   task automatic chk(string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("tod_sec", longint'(tod_sec), m_sec);
         chk("tod_ns", longint'(tod_ns), m_ns);
         chk("snap_valid", longint'(snap_valid), longint'(e_sv));
         chk("pps_out", longint'(pps_out), longint'(m_st == 2));
         if (e_sv) begin
            chk("snap_sec", longint'(snap_sec), e_ssec);
            chk("snap_ns", longint'(snap_ns), e_sns);
            chk("snap_frac", longint'(snap_frac), e_sfrac);
         end
      end
   end

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_trim(logic [31:0] v);
      trim_we = 1'b1; trim_wdata = v;
      run(1);
      trim_we = 1'b0;
   endtask

   task automatic do_load(longint s, longint n);
      load_en = 1'b1; load_sec = s[31:0]; load_ns = n[31:0];
      run(1);
      load_en = 1'b0;
   endtask

   task automatic do_step(int v);
      step_en = 1'b1; step_ns = v;
      run(1);
      step_en = 1'b0;
   endtask

   initial begin
      // R1: reset state at the ports
      run(3);
      @(negedge clk);
      chk("R1 tod_sec in reset", longint'(tod_sec), 0);
      chk("R1 tod_ns in reset", longint'(tod_ns), 0);
      chk("R1 pps_out in reset", longint'(pps_out), 0);
      chk("R1 snap_valid in reset", longint'(snap_valid), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      tag = "R1"; run(1);
      tag = "R2"; run(20);
      tag = "R3";
      do_trim(32'h7FFFFFFF); run(20);
      do_trim(32'hFFFFFFFF); run(20);
      do_trim(32'h80001234); run(10);
      do_trim(32'h00000007); run(10);
      do_trim(32'h0);
      tag = "R4";
      do_load(5, 999_999_950); run(10);
      do_load(64'hFFFFFFFF, 999_999_990); run(5);
      tag = "R5";
      load_en = 1'b1; load_sec = 100; load_ns = 500;
      step_en = 1'b1; step_ns = 1000;
      run(1);
      load_en = 1'b0; step_en = 1'b0;
      run(3);
      tag = "R6";
      do_step(999_999_999); run(2);
      do_step(-999_999_999); run(2);
      do_load(0, 5); do_step(-10); run(2);
      do_load(3, 999_999_990); do_step(1); run(2);
      do_load(4, 3); do_step(-20); run(2);
      do_load(6, 999_999_980); do_step(-5); run(2);
      tag = "R7";
      snap_req = 1'b1; run(1); snap_req = 1'b0; run(2);
      do_trim(32'h40000000); run(3);
      snap_req = 1'b1; run(2); snap_req = 1'b0; run(2);
      do_trim(32'h0);
      tag = "R8";
      do_load(7, 999_999_000);
      pps_en = 1'b1; run(2);
      tag = "R9"; run(120);
      do_load(8, 999_999_800); run(60);
      tag = "R8";
      pps_en = 1'b0; run(5);
      pps_en = 1'b1; run(2);
      tag = "R9";
      do_load(9, 999_999_900); run(20);
      tag = "R8";
      pps_en = 1'b0; run(4);
      tag = "R9";
      pps_width_ns = 32'd13;
      pps_en = 1'b1; run(2);
      do_load(10, 999_999_960); run(12);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule